// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block is a tiny first-level data cache sitting between a processor load/store port and a backing memory. It holds two lines of eight bytes, indexed directly by one address bit. Every store is forwarded to memory, hit or miss. A store that misses first pulls the whole line in and then merges the stored word, so memory never holds stale data and no line ever needs writing back.

The processor side accepts one request at a time: a request is taken when `req_valid_i` and `req_ready_o` are both high. The cache then answers with a one-cycle `rsp_done_o` pulse, together with the read word and a hit flag. The memory side is a single word-wide valid/ready channel used for line refills (two reads) and for store forwarding (one write). Read data must be valid in the cycle the read handshake completes.

Top module: `dcache_wt`

## Requirements
- R1: After reset every line is invalid: `req_ready_o` is 1, `rsp_done_o` and `mem_valid_o` are 0, and the first access to any address reports a miss.
- R2: Address decoding: bits [1:0] are ignored for lookup, bit [2] picks the word within a line, bit [3] picks the set, and bits [31:4] are the tag. Two addresses hit each other's line only when bits [31:3] are equal.
- R3: A read that hits raises `rsp_done_o` in the cycle after acceptance, with `rsp_hit_o`=1, the addressed word on `rsp_rdata_o`, and no memory traffic.
- R4: A read miss issues exactly two memory reads, first the line base (address bits [2:0]=0), then base+4. The line is then installed, and `rsp_done_o` follows with `rsp_hit_o`=0 and the requested word.
- R5: Every store issues exactly one memory write, carrying the store data to the word-aligned address (bits [1:0]=0). `rsp_done_o` comes only after that write handshake.
- R6: A store miss first refills the line with two reads, as in R4, and then merges the stored word. A later read of either word of that line hits, returning the stored data and the memory contents respectively.
- R7: A miss into an occupied set replaces the old line without any memory write for it. A later access to the old line misses.
- R8: Only one request is in flight: `req_ready_o` is 0 from the cycle after acceptance through the `rsp_done_o` cycle. A request presented while not ready is not taken and has no effect.
- R9: `rsp_hit_o` reflects the cache contents when the request was accepted. An access that needed a refill reports 0 even though it completes from the refilled line.
- R10: A 2x2 transpose of 4-byte words, with the source at byte 0 and the destination at byte 16 (read src[i][j], then write dst[j][i], row-major), gives source reads of miss, miss, miss, hit, and four destination write misses.
- R11: While `mem_valid_o` is 1 and `mem_ready_i` is 0, the memory request (address, direction, write data) holds steady into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Processor request valid |
| req_write_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | DATA_W | Store data |
| req_ready_o | output | 1 | Cache idle, request can be accepted |
| rsp_done_o | output | 1 | One-cycle completion pulse |
| rsp_hit_o | output | 1 | Hit flag, valid with done |
| rsp_rdata_o | output | DATA_W | Load data, valid with done |
| mem_valid_o | output | 1 | Memory word request valid |
| mem_write_o | output | 1 | 1 = word write, 0 = word read |
| mem_addr_o | output | ADDR_W | Word-aligned memory address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_ready_i | input | 1 | Memory accepts request this cycle |
| mem_rdata_i | input | DATA_W | Read data, valid with a read handshake |

## Verification
The bench targets conflict misses between lines that share a set: the transpose pattern and a long address sweep over four tags. A design that compared too few tag bits or indexed on the wrong bit would report false hits and return another line's data. Store misses are driven with the memory stalling at random. A design that skipped the allocate refill, or merged before the last beat, would later hit with stale sibling data. A design that dropped the write on a hit would leave the memory image different from the bench's model. While the cache is busy, the bench keeps a bogus store to another address asserted. A cache that accepted it would corrupt memory, and the final comparison against the model would catch it.

// File: rtl/dcache_wt_pkg.sv
package dcache_wt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL,
    ST_STORE,
    ST_RESP
  } ctrl_state_e;
endpackage

// File: rtl/dcache_tag_store.sv
module dcache_tag_store #(
  parameter int SETS  = 2,
  parameter int SET_W = 1,
  parameter int TAG_W = 28
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SET_W-1:0] lk_set_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  output logic             lk_hit_o,
  input  logic             inst_en_i,
  input  logic [SET_W-1:0] inst_set_i,
  input  logic [TAG_W-1:0] inst_tag_i
);
  logic [SETS-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) valid_q[s] <= 1'b0;
      else if (inst_en_i && inst_set_i == SET_W'(s)) valid_q[s] <= 1'b1;
    end
    always_ff @(posedge clk_i) begin
      if (inst_en_i && inst_set_i == SET_W'(s)) tag_q[s] <= inst_tag_i;
    end
  end

  assign lk_hit_o = valid_q[lk_set_i] && (tag_q[lk_set_i] == lk_tag_i);
endmodule

// File: rtl/dcache_data_store.sv
module dcache_data_store #(
  parameter int SETS   = 2,
  parameter int WORDS  = 2,
  parameter int DATA_W = 32,
  parameter int SET_W  = 1,
  parameter int WORD_W = 1
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [SET_W-1:0]  wset_i,
  input  logic [WORD_W-1:0] wword_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [SET_W-1:0]  rset_i,
  input  logic [WORD_W-1:0] rword_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int ENTRIES = SETS * WORDS;
  logic [DATA_W-1:0] mem_q [ENTRIES];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[{wset_i, wword_i}] <= wdata_i;
  end

  assign rdata_o = mem_q[{rset_i, rword_i}];
endmodule

// File: rtl/dcache_ctrl.sv
module dcache_ctrl
  import dcache_wt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 2,
  parameter int WORD_W = 1,
  parameter int SET_W  = 1,
  parameter int TAG_W  = 28
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              lk_hit_i,
  output logic              req_ready_o,
  output logic              rsp_done_o,
  output logic              rsp_hit_o,
  output logic              mem_valid_o,
  output logic              mem_write_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              dw_en_o,
  output logic [SET_W-1:0]  dw_set_o,
  output logic [WORD_W-1:0] dw_word_o,
  output logic [DATA_W-1:0] dw_data_o,
  output logic [SET_W-1:0]  rd_set_o,
  output logic [WORD_W-1:0] rd_word_o,
  output logic              tag_we_o,
  output logic [SET_W-1:0]  tag_set_o,
  output logic [TAG_W-1:0]  tag_val_o
);
  localparam int OFF_W = BYTE_W + WORD_W;
  localparam logic [WORD_W-1:0] LAST_BEAT = WORD_W'((1 << WORD_W) - 1);

  ctrl_state_e       state_q;
  logic [ADDR_W-1:BYTE_W] addr_q;
  logic              write_q, hit_q;
  logic [DATA_W-1:0] wdata_q;
  logic [WORD_W-1:0] beat_q;

  logic accept, beat_done;
  assign accept    = (state_q == ST_IDLE) && req_valid_i;
  assign beat_done = (state_q == ST_FILL) && mem_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      write_q <= 1'b0;
      hit_q   <= 1'b0;
      wdata_q <= '0;
      beat_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          addr_q  <= req_addr_i[ADDR_W-1:BYTE_W];
          write_q <= req_write_i;
          wdata_q <= req_wdata_i;
          hit_q   <= lk_hit_i;
          beat_q  <= '0;
          if (!lk_hit_i)        state_q <= ST_FILL;
          else if (req_write_i) state_q <= ST_STORE;
          else                  state_q <= ST_RESP;
        end
        ST_FILL: if (mem_ready_i) begin
          if (beat_q == LAST_BEAT) state_q <= write_q ? ST_STORE : ST_RESP;
          else                     beat_q  <= beat_q + 1'b1;
        end
        ST_STORE: if (mem_ready_i) state_q <= ST_RESP;
        ST_RESP:  state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  // Memory channel
  always_comb begin
    mem_valid_o = 1'b0;
    mem_write_o = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = wdata_q;
    if (state_q == ST_FILL) begin
      mem_valid_o = 1'b1;
      mem_addr_o  = {addr_q[ADDR_W-1:OFF_W], beat_q, {BYTE_W{1'b0}}};
    end else if (state_q == ST_STORE) begin
      mem_valid_o = 1'b1;
      mem_write_o = 1'b1;
      mem_addr_o  = {addr_q, {BYTE_W{1'b0}}};
    end
  end

  // Data array write: store hit at acceptance, or a refill beat (stored word merged in)
  always_comb begin
    dw_en_o   = 1'b0;
    dw_set_o  = addr_q[OFF_W +: SET_W];
    dw_word_o = beat_q;
    dw_data_o = mem_rdata_i;
    if (accept && lk_hit_i && req_write_i) begin
      dw_en_o   = 1'b1;
      dw_set_o  = req_addr_i[OFF_W +: SET_W];
      dw_word_o = req_addr_i[BYTE_W +: WORD_W];
      dw_data_o = req_wdata_i;
    end else if (beat_done) begin
      dw_en_o = 1'b1;
      if (write_q && beat_q == addr_q[BYTE_W +: WORD_W]) dw_data_o = wdata_q;
    end
  end

  assign tag_we_o    = beat_done && (beat_q == LAST_BEAT);
  assign tag_set_o   = addr_q[OFF_W +: SET_W];
  assign tag_val_o   = addr_q[ADDR_W-1 -: TAG_W];
  assign rd_set_o    = addr_q[OFF_W +: SET_W];
  assign rd_word_o   = addr_q[BYTE_W +: WORD_W];
  assign req_ready_o = (state_q == ST_IDLE);
  assign rsp_done_o  = (state_q == ST_RESP);
  assign rsp_hit_o   = rsp_done_o && hit_q;
endmodule

// File: rtl/dcache_wt.sv
module dcache_wt #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 8,
  parameter int NUM_SETS   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  output logic              rsp_done_o,
  output logic              rsp_hit_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              mem_valid_o,
  output logic              mem_write_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int WORD_BYTES = DATA_W / 8;
  localparam int BYTE_W     = $clog2(WORD_BYTES);
  localparam int WORDS      = LINE_BYTES / WORD_BYTES;
  localparam int WORD_W     = $clog2(WORDS);
  localparam int OFF_W      = BYTE_W + WORD_W;
  localparam int SET_W      = $clog2(NUM_SETS);
  localparam int TAG_W      = ADDR_W - OFF_W - SET_W;

  logic              lk_hit;
  logic              dw_en, tag_we;
  logic [SET_W-1:0]  dw_set, rd_set, tag_set;
  logic [WORD_W-1:0] dw_word, rd_word;
  logic [DATA_W-1:0] dw_data;
  logic [TAG_W-1:0]  tag_val;

  dcache_tag_store #(.SETS(NUM_SETS), .SET_W(SET_W), .TAG_W(TAG_W)) u_tags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lk_set_i   (req_addr_i[OFF_W +: SET_W]),
    .lk_tag_i   (req_addr_i[ADDR_W-1 -: TAG_W]),
    .lk_hit_o   (lk_hit),
    .inst_en_i  (tag_we),
    .inst_set_i (tag_set),
    .inst_tag_i (tag_val)
  );

  dcache_data_store #(
    .SETS(NUM_SETS), .WORDS(WORDS), .DATA_W(DATA_W), .SET_W(SET_W), .WORD_W(WORD_W)
  ) u_data (
    .clk_i   (clk_i),
    .we_i    (dw_en),
    .wset_i  (dw_set),
    .wword_i (dw_word),
    .wdata_i (dw_data),
    .rset_i  (rd_set),
    .rword_i (rd_word),
    .rdata_o (rsp_rdata_o)
  );

  dcache_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W),
    .WORD_W(WORD_W), .SET_W(SET_W), .TAG_W(TAG_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .lk_hit_i    (lk_hit),
    .req_ready_o (req_ready_o),
    .rsp_done_o  (rsp_done_o),
    .rsp_hit_o   (rsp_hit_o),
    .mem_valid_o (mem_valid_o),
    .mem_write_o (mem_write_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_ready_i (mem_ready_i),
    .mem_rdata_i (mem_rdata_i),
    .dw_en_o     (dw_en),
    .dw_set_o    (dw_set),
    .dw_word_o   (dw_word),
    .dw_data_o   (dw_data),
    .rd_set_o    (rd_set),
    .rd_word_o   (rd_word),
    .tag_we_o    (tag_we),
    .tag_set_o   (tag_set),
    .tag_val_o   (tag_val)
  );
endmodule

// File: rtl/dcache_wt_chk.sv
module dcache_wt_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_write_i,
  input logic              req_ready_o,
  input logic              lk_hit_i,
  input logic              rsp_done_o,
  input logic              rsp_hit_o,
  input logic              mem_valid_o,
  input logic              mem_write_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              mem_ready_i
);
  a_r8_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o);

  a_r8_done_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_done_o |-> !req_ready_o);

  a_r8_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_valid_o && !rsp_done_o);

  a_r3_read_hit_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && !req_write_i && lk_hit_i |=> rsp_done_o && rsp_hit_o);

  a_r9_miss_not_immediate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && !lk_hit_i |=> !rsp_done_o && mem_valid_o && !mem_write_o);

  a_r11_mem_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o)
      && $stable(mem_write_o) && $stable(mem_wdata_o));

  a_r2_word_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> mem_addr_o[1:0] == 2'b00);
endmodule

bind dcache_wt dcache_wt_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_write_i (req_write_i),
  .req_ready_o (req_ready_o),
  .lk_hit_i    (lk_hit),
  .rsp_done_o  (rsp_done_o),
  .rsp_hit_o   (rsp_hit_o),
  .mem_valid_o (mem_valid_o),
  .mem_write_o (mem_write_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ready_i (mem_ready_i)
);

// File: tb/dcache_wt_tb.sv
`timescale 1ns/1ps
module dcache_wt_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        req_ready, rsp_done, rsp_hit;
  logic [31:0] rsp_rdata;
  logic        mem_valid, mem_write;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_ready = 1'b1;

  always #5 clk = ~clk;

  dcache_wt u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .req_ready_o(req_ready), .rsp_done_o(rsp_done),
    .rsp_hit_o(rsp_hit), .rsp_rdata_o(rsp_rdata),
    .mem_valid_o(mem_valid), .mem_write_o(mem_write),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ready_i(mem_ready), .mem_rdata_i(mem_rdata)
  );

  int n_checks = 0, n_fail = 0;
  int cyc = 0;

  // backing memory (16 words) and its reference image
  logic [31:0] mem_arr [16];
  logic [31:0] ref_mem [16];
  assign mem_rdata = mem_arr[mem_addr[5:2]];

  int          n_rd, n_wr;
  logic [31:0] rd_a0, rd_a1, wr_a, wr_d;
  bit          stall_en = 1'b0;
  logic [7:0]  lfsr = 8'h5A;

  always @(posedge clk) begin
    if (mem_valid && mem_ready) begin
      if (mem_write) begin
        mem_arr[mem_addr[5:2]] <= mem_wdata;
        wr_a = mem_addr; wr_d = mem_wdata; n_wr++;
      end else begin
        if (n_rd == 0) rd_a0 = mem_addr; else rd_a1 = mem_addr;
        n_rd++;
      end
    end
  end

  always @(negedge clk) begin
    lfsr      <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_ready <= stall_en ? lfsr[0] : 1'b1;
  end

  // reference cache state
  bit          mv [2];
  logic [27:0] mt [2];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic do_reset();
    rst_n = 1'b0; req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mv[0] = 1'b0; mv[1] = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready after reset", {31'd0, req_ready}, 32'd1);
    check(rsp_done == 1'b0 && mem_valid == 1'b0, "R1 quiet after reset",
          {30'd0, rsp_done, mem_valid}, 32'd0);
  endtask

  // one access; poke keeps a bogus store asserted while busy (R8)
  task automatic access(input bit wr, input logic [31:0] a, input logic [31:0] wd,
                        input bit poke, output bit h, output logic [31:0] rd);
    bit          eh;
    int          lat = 0;
    int          busy_err = 0;
    logic [31:0] base;
    eh   = mv[a[3]] && mt[a[3]] == a[31:4];
    base = {a[31:3], 3'b000};
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    n_rd = 0; n_wr = 0;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    @(posedge clk);
    forever begin
      @(negedge clk);
      lat++;
      if (rsp_done || lat > 60) break;
      if (req_ready) busy_err++;
      req_valid = poke; req_write = 1'b1; req_addr = 32'h0000_003C; req_wdata = 32'hDEAD_BEEF;
    end
    if (req_ready) busy_err++;
    req_valid = 1'b0;
    h  = rsp_hit;
    rd = rsp_rdata;
    check(rsp_done, "R8 done seen", {31'd0, rsp_done}, 32'd1);
    check(busy_err == 0, "R8 not ready while busy", busy_err, 0);
    check(h == eh, "R9 hit flag", {31'd0, h}, {31'd0, eh});
    check(n_rd == (eh ? 0 : 2), "R4 refill read count", n_rd, eh ? 0 : 2);
    if (!eh) begin
      check(rd_a0 == base && rd_a1 == base + 4, "R4 refill order", rd_a0, base);
      check(n_rd == 2, "R6 allocate on miss", n_rd, 2);
    end
    check(n_wr == (wr ? 1 : 0), "R5 write count", n_wr, wr ? 1 : 0);
    if (wr) begin
      check(wr_a == {a[31:2], 2'b00} && wr_d == wd, "R5 write addr/data", wr_a, {a[31:2], 2'b00});
      ref_mem[a[5:2]] = wd;
    end else begin
      check(rd == ref_mem[a[5:2]], "R2 read data", rd, ref_mem[a[5:2]]);
      if (eh) check(lat == 1, "R3 hit latency", lat, 1);
    end
    mv[a[3]] = 1'b1; mt[a[3]] = a[31:4];
  endtask

  initial begin
    bit          h;
    logic [31:0] rd;
    logic [31:0] seed = 32'h1234_5678;
    bit          src_hits [4];
    bit          dst_hits [4];
    for (int k = 0; k < 16; k++) begin
      mem_arr[k] = 32'hA000_0000 + k;
      ref_mem[k] = 32'hA000_0000 + k;
    end
    do_reset();

    // R10 transpose, src at 0, dst at 16
    for (int i = 0; i < 2; i++)
      for (int j = 0; j < 2; j++) begin
        access(1'b0, 32'((i * 2 + j) * 4), 32'd0, 1'b0, h, rd);
        src_hits[i * 2 + j] = h;
        access(1'b1, 32'(16 + (j * 2 + i) * 4), rd, 1'b0, h, rd);
        dst_hits[i * 2 + j] = h;
      end
    check({src_hits[0], src_hits[1], src_hits[2], src_hits[3]} == 4'b0001, "R10 src pattern",
          {28'd0, src_hits[0], src_hits[1], src_hits[2], src_hits[3]}, 32'd1);
    check({dst_hits[0], dst_hits[1], dst_hits[2], dst_hits[3]} == 4'b0000, "R10 dst pattern",
          {28'd0, dst_hits[0], dst_hits[1], dst_hits[2], dst_hits[3]}, 32'd0);
    check(mem_arr[5] == 32'hA000_0002, "R10 dst[0][1]", mem_arr[5], 32'hA000_0002);

    // R6 store miss then sibling reads; R7 conflict replacement
    access(1'b1, 32'h0000_0024, 32'h5555_0001, 1'b0, h, rd);
    check(h == 1'b0, "R6 store miss", {31'd0, h}, 32'd0);
    access(1'b0, 32'h0000_0020, 32'd0, 1'b0, h, rd);
    check(h == 1'b1 && rd == ref_mem[8], "R6 sibling hit", rd, ref_mem[8]);
    access(1'b0, 32'h0000_0026, 32'd0, 1'b0, h, rd);
    check(h == 1'b1 && rd == 32'h5555_0001, "R6 merged word, R2 low bits ignored", rd, 32'h5555_0001);
    access(1'b0, 32'h0000_0030, 32'd0, 1'b0, h, rd);
    check(n_wr == 0, "R7 no write-back", n_wr, 0);
    access(1'b0, 32'h0000_0020, 32'd0, 1'b0, h, rd);
    check(h == 1'b0, "R7 old line evicted", {31'd0, h}, 32'd0);

    // R1 reset invalidates a resident line
    do_reset();
    access(1'b0, 32'h0000_0020, 32'd0, 1'b0, h, rd);
    check(h == 1'b0, "R1 miss after reset", {31'd0, h}, 32'd0);

    // sweep with stalls and busy-time pokes (R8, R11)
    stall_en = 1'b1;
    for (int n = 0; n < 600; n++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      access(seed[31], {26'd0, seed[13:8]}, seed ^ 32'h0F0F_3C3C, seed[30], h, rd);
    end
    stall_en = 1'b0;
    repeat (2) @(negedge clk);
    for (int k = 0; k < 16; k++)
      check(mem_arr[k] == ref_mem[k], "R5 memory image", mem_arr[k], ref_mem[k]);
    finish_run();
  end
endmodule